// File: doc/BRIEF.md
# Wake-up Reason Interrupt Controller

This block records the reason a power-management device came out of reset or left a low-power state, and presents that reason to a host processor. Seven cause lines feed it: start from the fully off state, start from hibernate, reset after a converter fault, reset after a missed watchdog heartbeat, a long press on the power-on pin, a long press on the on-key, and a long press on the wakeup pin. Each line first passes through a two-flop synchronizer. A rising edge on a line then sets a sticky status bit for that cause.

The host reaches two registers over a simple single-cycle read/write bus. The status register at address 0 returns all seven cause bits. Reading it clears them. The mask register at address 1 is a plain read/write register, and a 1 in any of its bits hides the matching cause. One level interrupt output, `wakeIrq`, is high while any status bit is set and its mask bit is clear. The host reads the status register after reset to find out why the device woke up.

Top module: `wake_cause_irq`

## Requirements
- R1: A rising edge on `wakeCause[i]` sets status bit i. The bit order is fixed: 6 = started from off, 5 = started from hibernate, 4 = converter-fault reset, 3 = missed-watchdog reset, 2 = power-on pin long press, 1 = on-key long press, 0 = wakeup pin long press.
- R2: Status bits are set by edges only. If a cause line stays high, its bit is not set again after a read has cleared it.
- R3: A read of address 0 (`busSel`=1, `busWr`=0) returns the status in `busRdata[6:0]` from the next clock edge onward. The value returned is the status from before the read, and the read clears every status bit.
- R4: If a cause edge reaches its status bit on the same clock edge as a status read, that bit stays set, and the data returned by the read does not include it.
- R5: Address 1 holds a read/write mask, one bit per cause at the same bit position, where 1 = masked. It resets to all zeros.
- R6: `wakeIrq` is 1 exactly when at least one status bit is 1 and its mask bit is 0. It follows the registers in the same cycle.
- R7: A masked cause still sets its status bit. The host can read that bit, but it does not raise `wakeIrq`.
- R8: `busRdata` bits 7 and above always read 0. A read of address 2 or 3 returns 0. Writes to the mask store only bits 6:0.
- R9: Writes to address 0 have no effect on the status bits.
- R10: A cause edge that is driven just before clock edge k shows up in the status bit and on `wakeIrq` after edge k+2, and not earlier.
- R11: While reset is held and right after it, the status is 0, `wakeIrq` is 0 and `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeCause | input | 7 | Asynchronous wake-up cause lines, bit order as in R1 |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address: 0 = status, 1 = mask |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered, updated by each read |
| wakeIrq | output | 1 | Summary wake-up interrupt |

## Verification
A table of vectors pulses different groups of cause lines under different masks. The set includes a single cause, a masked single cause, mixed masked and unmasked groups, every cause fully masked, and every cause with one unmasked bit. Comparing the read-back status with `wakeIrq` separates bits that are stored from bits that reach the interrupt, and shows whether each bit lands in its proper position. Directed cases cover a line held high across a clearing read (edge versus level), an edge arriving on the same clock as a read (event wins), the cycle on which a cause first becomes visible, writes to the status address, and reads of unmapped addresses.

// File: rtl/wake_cause_pkg.sv
package wake_cause_pkg;
  localparam int NUM_CAUSE   = 7;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;

  // cause bit positions (host software decodes these)
  localparam int CAUSE_FROM_OFF   = 6;
  localparam int CAUSE_FROM_HIB   = 5;
  localparam int CAUSE_CONV_FAULT = 4;
  localparam int CAUSE_WDOG_MISS  = 3;
  localparam int CAUSE_PWRON_PIN  = 2;
  localparam int CAUSE_ONKEY      = 1;
  localparam int CAUSE_WAKE_PIN   = 0;

  typedef struct packed {
    logic rdAny;
    logic rdStatus;
    logic rdMask;
    logic wrMask;
  } busStrobe_t;
endpackage

// File: rtl/wake_cause_sync.sv
module wake_cause_sync #(
  parameter int NUM    = 7,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] causeAsync,
  output logic [NUM-1:0] riseEvt
);
  generate
    for (genvar i = 0; i < NUM; i++) begin : g_line
      logic [STAGES-1:0] syncQ;
      logic              prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncQ <= '0;
          prevQ <= 1'b0;
        end else begin
          syncQ <= {syncQ[STAGES-2:0], causeAsync[i]};
          prevQ <= syncQ[STAGES-1];
        end
      end
      assign riseEvt[i] = syncQ[STAGES-1] & ~prevQ;
    end
  endgenerate
endmodule

// File: rtl/wake_cause_ctrl.sv
module wake_cause_ctrl
  import wake_cause_pkg::*;
#(
  parameter int AW        = 2,
  parameter int STAT_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  output busStrobe_t    strobe
);
  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus       = (busAddr == AW'(STAT_ADDR));
    hitMask         = (busAddr == AW'(MASK_ADDR));
    strobe.rdAny    = busSel & ~busWr;
    strobe.rdStatus = busSel & ~busWr & hitStatus;
    strobe.rdMask   = busSel & ~busWr & hitMask;
    strobe.wrMask   = busSel &  busWr & hitMask;
  end
endmodule

// File: rtl/wake_cause_dp.sv
module wake_cause_dp
  import wake_cause_pkg::*;
#(
  parameter int NUM = 7,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  busStrobe_t     strobe,
  input  logic [DW-1:0]  busWdata,
  input  logic [NUM-1:0] riseEvt,
  output logic [NUM-1:0] statusVec,
  output logic [NUM-1:0] maskVec,
  output logic [DW-1:0]  busRdata,
  output logic           wakeIrq
);
  logic [DW-1:0] rdValue;

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rstN) begin
          statusVec[i] <= 1'b0;
        end else if (riseEvt[i]) begin
          statusVec[i] <= 1'b1;          // new event wins over clear
        end else if (strobe.rdStatus) begin
          statusVec[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              maskVec <= '0;
    else if (strobe.wrMask) maskVec <= busWdata[NUM-1:0];
  end

  always_comb begin
    rdValue = '0;
    if (strobe.rdStatus)    rdValue = DW'(statusVec);
    else if (strobe.rdMask) rdValue = DW'(maskVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdata <= '0;
    else if (strobe.rdAny) busRdata <= rdValue;
  end

  assign wakeIrq = |(statusVec & ~maskVec);
endmodule

// File: rtl/wake_cause_irq.sv
module wake_cause_irq
  import wake_cause_pkg::*;
#(
  parameter int N_CAUSE = NUM_CAUSE,
  parameter int DW      = DATA_W,
  parameter int AW      = ADDR_W,
  parameter int NSYNC   = SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_CAUSE-1:0] wakeCause,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [AW-1:0]      busAddr,
  input  logic [DW-1:0]      busWdata,
  output logic [DW-1:0]      busRdata,
  output logic               wakeIrq
);
  busStrobe_t         strobe;
  logic [N_CAUSE-1:0] riseEvt;
  logic [N_CAUSE-1:0] statusVec;
  logic [N_CAUSE-1:0] maskVec;

  wake_cause_sync #(.NUM(N_CAUSE), .STAGES(NSYNC)) u_sync (
    .clk(clk), .rstN(rstN), .causeAsync(wakeCause), .riseEvt(riseEvt));

  wake_cause_ctrl #(.AW(AW), .STAT_ADDR(ADDR_STATUS), .MASK_ADDR(ADDR_MASK)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .strobe(strobe));

  wake_cause_dp #(.NUM(N_CAUSE), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .riseEvt(riseEvt), .statusVec(statusVec), .maskVec(maskVec),
    .busRdata(busRdata), .wakeIrq(wakeIrq));
endmodule

// File: rtl/wake_cause_chk.sv
module wake_cause_chk
  import wake_cause_pkg::*;
#(
  parameter int N_CAUSE = NUM_CAUSE,
  parameter int DW      = DATA_W,
  parameter int AW      = ADDR_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [N_CAUSE-1:0] wakeCause,
  input logic               busSel,
  input logic               busWr,
  input logic [AW-1:0]      busAddr,
  input logic [DW-1:0]      busRdata,
  input logic               wakeIrq,
  input logic [N_CAUSE-1:0] statusVec,
  input logic [N_CAUSE-1:0] maskVec
);
  logic rdStat;
  logic rdMsk;
  assign rdStat = busSel && !busWr && (busAddr == AW'(ADDR_STATUS));
  assign rdMsk  = busSel && !busWr && (busAddr == AW'(ADDR_MASK));

  // R1 / R9: a status bit only appears if its line was high three edges back
  p_set_needs_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & ~$past(statusVec)) & ~$past(wakeCause, 3)) == '0);

  // R2: without a status read, set bits stay set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdStat) |-> ((statusVec & $past(statusVec)) == $past(statusVec)));

  // R3: read data equals pre-clear status
  p_read_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdStat |=> (busRdata == DW'($past(statusVec))));

  // R5: mask read-back
  p_mask_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdMsk |=> (busRdata == DW'($past(maskVec))));

  // R6: full mask keeps the interrupt low
  p_full_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |-> !wakeIrq);

  // R6: interrupt needs a pending status bit
  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (statusVec != '0));

  // R8: upper read bits are zero
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DW-1:N_CAUSE] == '0);
endmodule

bind wake_cause_irq wake_cause_chk #(.N_CAUSE(N_CAUSE), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wakeCause(wakeCause), .busSel(busSel),
  .busWr(busWr), .busAddr(busAddr), .busRdata(busRdata), .wakeIrq(wakeIrq),
  .statusVec(statusVec), .maskVec(maskVec));

// File: tb/wake_cause_irq_bench.sv
module wake_cause_irq_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] wakeCause;
  logic       busSel, busWr;
  logic [1:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       wakeIrq;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  wake_cause_irq u_wake_cause_irq (
    .clk(clk), .rstN(rstN), .wakeCause(wakeCause), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .wakeIrq(wakeIrq));

  typedef struct packed {
    logic [6:0] cause;
    logic [6:0] mask;
    logic [6:0] expStat;
    logic       expIrq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{7'h40, 7'h00, 7'h40, 1'b1},
    '{7'h20, 7'h20, 7'h20, 1'b0},
    '{7'h18, 7'h08, 7'h18, 1'b1},
    '{7'h07, 7'h07, 7'h07, 1'b0},
    '{7'h55, 7'h2A, 7'h55, 1'b1},
    '{7'h7F, 7'h7F, 7'h7F, 1'b0},
    '{7'h01, 7'h7E, 7'h01, 1'b1}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wakeCause = '0; busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 irq in reset", {7'b0, wakeIrq}, 8'h00);
    check("R11 rdata in reset", busRdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    busRead(2'd0, rd);
    check("R11 status after reset", rd, 8'h00);
    busRead(2'd1, rd);
    check("R5 mask resets to 0", rd, 8'h00);

    // vector table: R1 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      busWrite(2'd1, {1'b0, VECS[v].mask});
      wakeCause = VECS[v].cause;
      repeat (4) @(negedge clk);
      wakeCause = '0;
      @(negedge clk);
      check("R6 R7 irq vs mask", {7'b0, wakeIrq}, {7'b0, VECS[v].expIrq});
      busRead(2'd0, rd);
      check("R1 R7 status bits", rd, {1'b0, VECS[v].expStat});
      check("R3 irq after clearing read", {7'b0, wakeIrq}, 8'h00);
    end
    busWrite(2'd1, 8'h00);

    // R10: latency through synchronizer
    wakeCause = 7'h08;
    @(negedge clk);
    @(negedge clk);
    check("R10 not visible after two edges", {7'b0, wakeIrq}, 8'h00);
    @(negedge clk);
    check("R10 visible after three edges", {7'b0, wakeIrq}, 8'h01);
    // R2: level held, read clears, no re-set
    repeat (2) @(negedge clk);
    busRead(2'd0, rd);
    check("R3 read value", rd, 8'h08);
    repeat (5) @(negedge clk);
    busRead(2'd0, rd);
    check("R2 held level does not re-set", rd, 8'h00);
    wakeCause = '0;
    repeat (4) @(negedge clk);

    // R4: edge on the same clock as a read
    wakeCause = 7'h40;
    repeat (4) @(negedge clk);
    wakeCause = 7'h41;             // bit 0 reaches status at third edge
    repeat (2) @(negedge clk);
    busRead(2'd0, rd);
    check("R4 read excludes coincident event", rd, 8'h40);
    check("R4 coincident event raises irq", {7'b0, wakeIrq}, 8'h01);
    busRead(2'd0, rd);
    check("R4 coincident event kept", rd, 8'h01);
    wakeCause = '0;
    repeat (4) @(negedge clk);

    // R9: write to status ignored
    wakeCause = 7'h10;
    repeat (4) @(negedge clk);
    busWrite(2'd0, 8'h00);
    check("R9 irq after status write", {7'b0, wakeIrq}, 8'h01);
    busWrite(2'd0, 8'h7F);
    busRead(2'd0, rd);
    check("R9 status unchanged by writes", rd, 8'h10);
    wakeCause = '0;
    repeat (4) @(negedge clk);

    // R8: upper bits and unmapped addresses
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, rd);
    check("R8 mask upper bit zero", rd, 8'h7F);
    busRead(2'd2, rd);
    check("R8 unmapped addr 2", rd, 8'h00);
    busRead(2'd3, rd);
    check("R8 unmapped addr 3", rd, 8'h00);
    busWrite(2'd1, 8'h00);
    busRead(2'd1, rd);
    check("R5 mask write back to 0", rd, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule